// File: doc/BRIEF.md
# I2S Slave Stereo Receiver

This block receives a stereo serial audio stream in the standard I2S format. It does not generate the bit clock or the word clock. Both come from outside: from an external codec, or from a transmitter on the same chip that drives the same two lines, which gives synchronised full-duplex operation. The bit clock, the word clock and the serial data all pass through a synchroniser into the system clock domain. The block finds the rising edges of the bit clock there and samples the data on them.

Each channel slot is 32 bit periods long and is sent most significant bit first. The word clock is low for the left channel and high for the right channel. The first bit of a slot arrives one bit period after the word-clock transition. The bit sampled in the period of the transition is the last bit of the previous slot. Bits are stored in the order they arrive on the wire, so the first bit lands in bit 31. A 24-bit sample therefore appears in bits 31..8. When a left slot and the following right slot are both complete, the pair is offered on a valid/ready output.

After reset the block discards everything until it sees the word clock fall, which marks the start of a left slot. The first pair delivered is therefore a whole frame. If the consumer has not taken the previous pair when a new pair completes, the new pair is dropped and a sticky overrun flag is raised.

Top module: `i2s_slave_rx`

## Requirements
- R1: While reset is held and directly after it is released, `outValid` and `overrun` are 0.
- R2: Data is sampled on rising bit-clock edges. The first bit of a slot is the one sampled one bit period after the word-clock edge, and it is stored in bit 31. The bit sampled in the period of the edge is stored in bit 0 of the slot that is ending.
- R3: The slot received while the word clock is low appears on `outLeft`, and the slot received while it is high appears on `outRight` of the same pair.
- R4: Until the first falling edge of the word clock after reset, no pair is delivered. The first pair delivered is the first frame whose left slot starts at or after that edge.
- R5: While `outValid` is 1 and `outReady` is 0, `outValid`, `outLeft` and `outRight` hold their values.
- R6: If a pair completes while `outValid` is 1 and `outReady` is 0, that pair is discarded and `overrun` becomes 1. `overrun` stays 1 until reset.
- R7: If a pair completes in the same cycle that the consumer takes the pending pair, the new pair is loaded, `outValid` stays 1 and `overrun` is not set.
- R8: A slot that does not span exactly 32 bit periods invalidates its frame, and that frame is not delivered. Reception resumes with the next complete frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | External bit clock, asynchronous to `clk` |
| wsIn | input | 1 | External word clock (0 = left, 1 = right) |
| sdIn | input | 1 | Serial data, which changes on falling bit-clock edges |
| outReady | input | 1 | Consumer accepts the pending pair |
| outValid | output | 1 | A received pair is pending |
| outLeft | output | 32 | Left slot, first received bit in bit 31 |
| outRight | output | 32 | Right slot, first received bit in bit 31 |
| overrun | output | 1 | Sticky flag: a completed pair was dropped |

## Verification
Completion of a new pair and the consumer's acceptance of the pending pair can fall on the same system clock edge. The bench provokes this by holding the consumer off after one pair is delivered. It then raises `outReady` for exactly the one cycle in which the synchronised bit-clock rise, at the left-slot start after the next pair, loads that pair. The bench judges the result from three observations: the old pair must be recorded once by the consumer, the new pair must be on the output with `outValid` still 1, and `overrun` must stay 0. A later test completes a pair while the consumer is stalled for the whole period, to show the case where the flag must be set.

// File: rtl/i2s_rx_pkg.sv
`timescale 1ns/100ps
package i2s_rx_pkg;

  // Strobes from the control unit to the datapath, one cycle wide each.
  typedef struct packed {
    logic shiftEn;   // rising bit-clock edge: shift the sampled bit in
    logic takeLeft;  // a complete left slot ends at this edge
    logic publish;   // a complete right slot ends and the pair is loaded
  } rxStrobe_t;

endpackage

// File: rtl/i2s_rx_sync.sv
`timescale 1ns/100ps
module i2s_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/i2s_rx_ctrl.sv
`timescale 1ns/100ps
module i2s_rx_ctrl
  import i2s_rx_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclkS,
  input  logic       wsS,
  input  logic       outReady,
  output rxStrobe_t  strobe,
  output logic       outValid,
  output logic       overrun
);

  localparam int CW = $clog2(SLOT_BITS) + 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SLOT_BITS - 1);
  localparam logic [CW-1:0] CNT_SAT  = {CW{1'b1}};

  logic          bclkD;
  logic          wsPrev;
  logic [CW-1:0] bitCnt;
  logic          armed;
  logic          leftHave;

  logic bitRise, wsEdge, slotFull, leftDone, rightDone, canTake;

  always_comb begin
    bitRise   = bclkS & ~bclkD;
    wsEdge    = bitRise & (wsS != wsPrev);
    slotFull  = (bitCnt == CNT_LAST);
    leftDone  = wsEdge & ~wsPrev & armed & slotFull;
    rightDone = wsEdge & wsPrev & armed & slotFull & leftHave;
    canTake   = ~outValid | outReady;
    strobe.shiftEn  = bitRise;
    strobe.takeLeft = leftDone;
    strobe.publish  = rightDone & canTake;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkD    <= 1'b0;
      wsPrev   <= 1'b0;
      bitCnt   <= CNT_SAT;
      armed    <= 1'b0;
      leftHave <= 1'b0;
      outValid <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      bclkD <= bclkS;
      if (bitRise) begin
        wsPrev <= wsS;
        if (wsEdge)                bitCnt <= '0;
        else if (bitCnt != CNT_SAT) bitCnt <= bitCnt + CW'(1);
      end
      if (wsEdge & wsPrev) armed <= 1'b1;
      if (wsEdge) leftHave <= ~wsPrev & armed & slotFull;
      if (strobe.publish)  outValid <= 1'b1;
      else if (outReady)   outValid <= 1'b0;
      if (rightDone & ~canTake) overrun <= 1'b1;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R6
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(outValid && !outReady)); // R6
  AST_IDLE_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !outValid); // R4
  AST_SWAP_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish && outValid |=> outValid && !overrun || $past(overrun)); // R7

endmodule

// File: rtl/i2s_rx_dpath.sv
`timescale 1ns/100ps
module i2s_rx_dpath
  import i2s_rx_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdS,
  input  rxStrobe_t            strobe,
  output logic [SLOT_BITS-1:0] outLeft,
  output logic [SLOT_BITS-1:0] outRight
);

  logic [SLOT_BITS-1:0] shiftReg;
  logic [SLOT_BITS-1:0] leftHold;
  logic [SLOT_BITS-1:0] curWord;

  // Word as it stands after the bit sampled at this edge.
  assign curWord = {shiftReg[SLOT_BITS-2:0], sdS};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      leftHold <= '0;
      outLeft  <= '0;
      outRight <= '0;
    end else begin
      if (strobe.shiftEn)  shiftReg <= curWord;
      if (strobe.takeLeft) leftHold <= curWord;
      if (strobe.publish) begin
        outLeft  <= leftHold;
        outRight <= curWord;
      end
    end
  end

  AST_ONE_SLOT_END: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.takeLeft, strobe.publish})); // R3
  AST_END_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeLeft || strobe.publish |-> strobe.shiftEn); // R2

endmodule

// File: rtl/i2s_slave_rx.sv
`timescale 1ns/100ps
module i2s_slave_rx
  import i2s_rx_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bclkIn,
  input  logic                 wsIn,
  input  logic                 sdIn,
  input  logic                 outReady,
  output logic                 outValid,
  output logic [SLOT_BITS-1:0] outLeft,
  output logic [SLOT_BITS-1:0] outRight,
  output logic                 overrun
);

  logic [2:0] lineSync;
  rxStrobe_t  strobe;

  i2s_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({bclkIn, wsIn, sdIn}),
    .syncOut (lineSync)
  );

  i2s_rx_ctrl #(.SLOT_BITS(SLOT_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bclkS    (lineSync[2]),
    .wsS      (lineSync[1]),
    .outReady (outReady),
    .strobe   (strobe),
    .outValid (outValid),
    .overrun  (overrun)
  );

  i2s_rx_dpath #(.SLOT_BITS(SLOT_BITS)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .sdS      (lineSync[0]),
    .strobe   (strobe),
    .outLeft  (outLeft),
    .outRight (outRight)
  );

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outLeft) && $stable(outRight)); // R5

endmodule

// File: tb/i2s_slave_rx_test.sv
`timescale 1ns/100ps
module i2s_slave_rx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bclkIn = 1'b0;
  logic        wsIn = 1'b0;
  logic        sdIn = 1'b0;
  logic        outReady = 1'b0;
  logic        outValid;
  logic [31:0] outLeft;
  logic [31:0] outRight;
  logic        overrun;

  int testsRun = 0;
  int testsFail = 0;
  logic pendLsb = 1'b0;

  logic [31:0] expL [16];
  logic [31:0] expR [16];
  int expWr = 0;
  int rxIdx = 0;

  localparam int NVEC = 6;
  localparam logic [63:0] VEC [NVEC] = '{
    64'h12345600_ABCDEF00,   // 24-bit samples in bits 31..8
    64'hFFFFFFFF_00000000,
    64'h80000001_7FFFFFFE,
    64'hAAAAAAAA_55555555,
    64'h00000001_80000000,
    64'hC3A5F00F_0F5A3CC3
  };

  always #2 clk = ~clk;   // 250 MHz

  i2s_slave_rx uut (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .wsIn(wsIn), .sdIn(sdIn),
    .outReady(outReady), .outValid(outValid), .outLeft(outLeft),
    .outRight(outRight), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  endtask

  // Consumer monitor: samples between edges; a transfer happens on the next rising edge.
  always @(negedge clk) begin
    #1;
    if (rstN && outValid && outReady) begin
      check(outLeft == expL[rxIdx], "R2/R3", "left word", outLeft, expL[rxIdx]);
      check(outRight == expR[rxIdx], "R2/R3", "right word", outRight, expR[rxIdx]);
      rxIdx++;
    end
  end

  task automatic bitPeriod(input logic w, input logic d, input bit pulse);
    @(negedge clk); bclkIn = 1'b0; wsIn = w; sdIn = d;
    repeat (3) @(negedge clk);
    @(negedge clk); bclkIn = 1'b1;
    if (pulse) begin
      @(negedge clk);
      @(negedge clk); #0.5 outReady = 1'b1;
      @(negedge clk); #0.5 outReady = 1'b0;
    end else begin
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic sendSlot(input logic w, input logic [31:0] word, input int n, input bit pulseFirst);
    for (int j = 0; j < n; j++) begin
      bitPeriod(w, (j == 0) ? pendLsb : word[32-j], pulseFirst && (j == 0));
    end
    pendLsb = word[0];
  endtask

  task automatic pushExp(input logic [31:0] l, input logic [31:0] r);
    expL[expWr] = l;
    expR[expWr] = r;
    expWr++;
  endtask

  initial begin
    repeat (1000 * 150) @(posedge clk);
    testsFail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (5) @(negedge clk);
    check(outValid == 1'b0 && overrun == 1'b0, "R1", "outputs in reset",
          {30'd0, outValid, overrun}, 32'd0);
    #0.5 rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && overrun == 1'b0, "R1", "outputs after reset",
          {30'd0, outValid, overrun}, 32'd0);

    // R4: junk frame before the first falling edge of the word clock
    #0.5 outReady = 1'b1;
    sendSlot(1'b0, 32'hDEADBEEF, 32, 1'b0);
    sendSlot(1'b1, 32'hFEEDFACE, 32, 1'b0);
    check(outValid == 1'b0 && rxIdx == 0, "R4", "nothing before arming",
          {31'd0, outValid}, 32'd0);

    // Vector table walk, consumer always ready (R2, R3)
    for (int v = 0; v < NVEC; v++) begin
      pushExp(VEC[v][63:32], VEC[v][31:0]);
      sendSlot(1'b0, VEC[v][63:32], 32, 1'b0);
      sendSlot(1'b1, VEC[v][31:0], 32, 1'b0);
    end
    sendSlot(1'b0, 32'h0BADF00D, 32, 1'b0);          // frame F1 left
    check(rxIdx == NVEC, "R4", "pairs after vector walk", rxIdx, NVEC);

    // R7: completion and acceptance in the same cycle
    @(negedge clk); #0.5 outReady = 1'b0;
    pushExp(32'h0BADF00D, 32'h13579BDF);
    sendSlot(1'b1, 32'h13579BDF, 32, 1'b0);
    sendSlot(1'b0, 32'h2468ACE0, 32, 1'b0);          // A2 left, F1 delivered and held
    check(outValid == 1'b1 && outLeft == 32'h0BADF00D, "R5", "held pair",
          outLeft, 32'h0BADF00D);
    pushExp(32'h2468ACE0, 32'h76543210);
    sendSlot(1'b1, 32'h76543210, 32, 1'b0);
    sendSlot(1'b0, 32'h11112222, 32, 1'b1);          // F3 left, ready pulse at A2 completion
    check(rxIdx == NVEC + 1, "R7", "old pair taken once", rxIdx, NVEC + 1);
    check(outValid == 1'b1 && outLeft == 32'h2468ACE0, "R7", "new pair loaded",
          outLeft, 32'h2468ACE0);
    check(outRight == 32'h76543210, "R7", "new right loaded", outRight, 32'h76543210);
    check(overrun == 1'b0, "R7", "no overrun on swap", {31'd0, overrun}, 32'd0);

    // R6: completion while stalled
    sendSlot(1'b1, 32'h33334444, 32, 1'b0);
    sendSlot(1'b0, 32'h5A5A0001, 32, 1'b0);          // F3 completes, dropped
    check(overrun == 1'b1, "R6", "overrun set", {31'd0, overrun}, 32'd1);
    check(outValid == 1'b1 && outLeft == 32'h2468ACE0, "R5", "pair kept during stall",
          outLeft, 32'h2468ACE0);
    @(negedge clk); #0.5 outReady = 1'b1;
    repeat (4) @(negedge clk);
    check(rxIdx == NVEC + 2, "R6", "only held pair delivered", rxIdx, NVEC + 2);
    check(outValid == 1'b0, "R6", "dropped pair absent", {31'd0, outValid}, 32'd0);

    // R8: short slot kills its frame
    pushExp(32'h5A5A0001, 32'hA5A50002);
    sendSlot(1'b1, 32'hA5A50002, 32, 1'b0);
    sendSlot(1'b0, 32'hBBBBBBBB, 20, 1'b0);          // short left
    sendSlot(1'b1, 32'hCCCCCCCC, 32, 1'b0);
    pushExp(32'h9ABCDEF0, 32'h0FEDCBA9);
    sendSlot(1'b0, 32'h9ABCDEF0, 32, 1'b0);
    check(rxIdx == NVEC + 3, "R8", "short-slot frame not delivered", rxIdx, NVEC + 3);
    sendSlot(1'b1, 32'h0FEDCBA9, 32, 1'b0);
    sendSlot(1'b0, 32'h00000000, 32, 1'b0);
    check(rxIdx == NVEC + 4, "R8", "reception resumed", rxIdx, NVEC + 4);
    check(overrun == 1'b1, "R6", "overrun sticky", {31'd0, overrun}, 32'd1);

    finishRun();
  end

endmodule